// File: doc/BRIEF.md
# Dual-Rail Return-to-NULL Register Stage

This block is one register of a dual-rail pipeline that moves data with a four-phase, return-to-NULL handshake. Each bit travels as a pair of rails. A pair with neither rail high is NULL (a spacer). A pair with exactly one rail high is a DATA bit. Every output rail is a 2-of-2 hysteretic threshold gate. Its two inputs are the matching incoming rail and the request from the next stage. The gate goes high when both inputs are high, goes low when both are low, and otherwise keeps its value. A completion detector watches every output pair. It tells the previous stage whether this stage now holds a full DATA word, which asks for NULL, or a full NULL word, which asks for DATA.

Each threshold gate and the completion detector is a state element that is re-evaluated on every edge of `clk`. Because of this, any skew between rails, counted in whole cycles, is tolerated. Stages chain by wiring a stage's `req_in` to the inverse of the `ack_out` of the stage after it. There is no valid/ready pair at the edges. The handshake itself provides back-pressure: a stage will not take new DATA until the stage after it asks for DATA. It also keeps a DATA word until that stage asks for NULL and the input has gone back to NULL.

Top module: `ncl_reg_stage`

## Requirements
- R1: While `rst_n` is low, and after it is released until inputs change, every output rail is 0 and `ack_out` is 0 (meaning "request DATA").
- R2: Pair i occupies bits [2i+1:2i]. 00 is NULL, 01 (bit 2i high) is DATA 0, 10 (bit 2i+1 high) is DATA 1, and 11 is illegal. When the inputs carry only legal codes, no output pair ever shows 11.
- R3: An output rail goes high on the clock edge at which both its input rail and `req_in` are sampled high.
- R4: A high output rail stays high while either its input rail or `req_in` is high. It goes low on the edge at which both are sampled low.
- R5: `ack_out` rises one edge after every output pair holds DATA.
- R6: `ack_out` falls one edge after every output pair is NULL. While the output is partly DATA and partly NULL, `ack_out` keeps its previous value.
- R7: While `req_in` is low, a DATA code on the input sets no output rail.
- R8: In a chain of stages fed by a source that obeys the handshake, every word arrives at the end in order, with no loss and no duplication, for any per-rail skew.
- R9: The number of bit pairs is set by the parameter `WIDTH` (default 4, which gives 8 rails).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock for the threshold gates and the completion detector |
| rst_n | input | 1 | Active-low reset; forces NULL outputs and a DATA request |
| din_rails | input | 2*WIDTH | Incoming dual-rail word, pair i at bits [2i+1:2i] |
| req_in | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for NULL |
| dout_rails | output | 2*WIDTH | Registered dual-rail word |
| ack_out | output | 1 | Completion toward the previous stage: 1 means "holds DATA, send NULL" |

## Verification
The assertions rely on the input rails never carrying the illegal 11 code. They also rely on the previous stage changing `din_rails` only in the direction the handshake allows, so that a pair never jumps from one DATA value straight to the other. The bench's source keeps to this rule. It raises rails for a new word only after `ack_out` asks for DATA, and it lowers them only after `ack_out` asks for NULL. Each rail is delayed by a random 0 to 3 cycles. The sink raises and drops the last stage's request in the same ordered way.

// File: rtl/ncl_pkg.sv
package ncl_pkg;
  // A dual-rail pair carries DATA when at least one rail is high.
  function automatic logic pair_has_data(input logic [1:0] pr);
    return pr[0] | pr[1];
  endfunction
endpackage

// File: rtl/th22_cell.sv
module th22_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q
);
  // Hysteretic 2-of-2 threshold: set on both high, clear on both low, else hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (a && b)     q <= 1'b1;
    else if (!a && !b)   q <= 1'b0;
  end
endmodule

// File: rtl/ncl_done_detect.sv
module ncl_done_detect
  import ncl_pkg::*;
#(
  parameter int PAIRS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*PAIRS-1:0] rails,
  output logic               done
);
  logic [PAIRS-1:0] pair_data;
  logic             every_data;
  logic             every_null;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_data[p] = pair_has_data(rails[2*p +: 2]);
  end

  assign every_data = &pair_data;
  assign every_null = ~|pair_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done <= 1'b0;
    else if (every_data) done <= 1'b1;
    else if (every_null) done <= 1'b0;
  end
endmodule

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage
  import ncl_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*WIDTH-1:0] din_rails,
  input  logic               req_in,
  output logic [2*WIDTH-1:0] dout_rails,
  output logic               ack_out
);
  localparam int RAILS = 2 * WIDTH;

  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    th22_cell u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .a    (din_rails[g]),
      .b    (req_in),
      .q    (dout_rails[g])
    );

    // R3
    rail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_rails[g]) |-> $past(req_in && din_rails[g]));

    // R4
    rail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_rails[g]) |-> $past(!req_in && !din_rails[g]));
  end

  for (genvar p = 0; p < WIDTH; p++) begin : g_legal
    // R2
    pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_rails[2*p +: 2] != 2'b11);
  end

  ncl_done_detect #(.PAIRS(WIDTH)) u_done (
    .clk  (clk),
    .rst_n(rst_n),
    .rails(dout_rails),
    .done (ack_out)
  );

  // Full-word view used by the handshake checks below.
  logic word_full;
  always_comb begin
    word_full = 1'b1;
    for (int p = 0; p < WIDTH; p++)
      if (!pair_has_data(dout_rails[2*p +: 2])) word_full = 1'b0;
  end

  // R5
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(word_full));

  // R6
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> $past(dout_rails == '0));
endmodule

// File: tb/ncl_reg_stage_test.sv
module ncl_reg_stage_test;
  localparam int W = 4;
  localparam int R = 2 * W;
  localparam int NWORDS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Standalone stage for directed checks.
  logic [R-1:0] d_in = '0;
  logic         d_req = 1'b0;
  logic [R-1:0] d_out;
  logic         d_ack;

  ncl_reg_stage #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .din_rails(d_in), .req_in(d_req),
    .dout_rails(d_out), .ack_out(d_ack));

  // Three-stage chain for the streaming check (R8).
  logic [R-1:0] src = '0;
  logic [R-1:0] o0, o1, o2;
  logic         a0, a1, a2;
  logic         sink_req = 1'b1;

  ncl_reg_stage #(.WIDTH(W)) u_s0 (.clk(clk), .rst_n(rst_n), .din_rails(src),
    .req_in(~a1), .dout_rails(o0), .ack_out(a0));
  ncl_reg_stage #(.WIDTH(W)) u_s1 (.clk(clk), .rst_n(rst_n), .din_rails(o0),
    .req_in(~a2), .dout_rails(o1), .ack_out(a1));
  ncl_reg_stage #(.WIDTH(W)) u_s2 (.clk(clk), .rst_n(rst_n), .din_rails(o1),
    .req_in(sink_req), .dout_rails(o2), .ack_out(a2));

  function automatic logic [R-1:0] enc(input int v);
    logic [R-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic int dec(input logic [R-1:0] r);
    int v = 0;
    for (int i = 0; i < W; i++) if (r[2*i+1]) v |= (1 << i);
    return v;
  endfunction

  function automatic logic full(input logic [R-1:0] r);
    for (int i = 0; i < W; i++) if (r[2*i +: 2] == 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R2 monitor on the chain.
  logic illegal_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n)
      for (int i = 0; i < W; i++)
        if (o0[2*i +: 2] == 2'b11 || o1[2*i +: 2] == 2'b11 || o2[2*i +: 2] == 2'b11)
          illegal_seen = 1'b1;
  end

  int words[NWORDS];
  int rx_count = 0;

  task automatic send(input int v);
    logic [R-1:0] tgt;
    int cd[R];
    tgt = enc(v);
    while (a0 !== 1'b0) @(negedge clk);
    for (int r = 0; r < R; r++) cd[r] = $urandom_range(0, 3);
    while (src != tgt) begin
      for (int r = 0; r < R; r++)
        if (tgt[r] && !src[r]) begin
          if (cd[r] == 0) src[r] = 1'b1; else cd[r]--;
        end
      @(negedge clk);
    end
    while (a0 !== 1'b1) @(negedge clk);
    for (int r = 0; r < R; r++) cd[r] = $urandom_range(0, 3);
    while (src != '0) begin
      for (int r = 0; r < R; r++)
        if (src[r]) begin
          if (cd[r] == 0) src[r] = 1'b0; else cd[r]--;
        end
      @(negedge clk);
    end
  endtask

  task automatic sink_loop();
    forever begin
      @(negedge clk);
      if (rst_n && sink_req && full(o2)) begin
        if (rx_count < NWORDS) chk("R8 order", dec(o2), words[rx_count]);
        rx_count++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        sink_req = 1'b0;
        while (o2 !== '0) @(negedge clk);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        sink_req = 1'b1;
      end
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NWORDS; i++) words[i] = $urandom_range(0, 15);
    words[0] = 0;
    words[1] = 15;
    words[2] = 15;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rails", d_out, 0);
    chk("R1 reset ack", d_ack, 0);

    fork sink_loop(); join_none

    // Partial DATA with request high.
    d_req = 1'b1; d_in = 8'h01;
    @(negedge clk);
    chk("R3 partial rise", d_out, 8'h01);
    @(negedge clk);
    chk("R6 hold on partial", d_ack, 0);

    // Full word 10.
    d_in = enc(10);
    @(negedge clk);
    chk("R3 full word", d_out, 8'h99);
    chk("R5 ack lag", d_ack, 0);
    @(negedge clk);
    chk("R5 ack rise", d_ack, 1);

    // Request NULL with DATA still present: hold.
    d_req = 1'b0;
    @(negedge clk);
    chk("R4 hold req low", d_out, 8'h99);

    // Input NULL with request high: hold.
    d_req = 1'b1; d_in = '0;
    @(negedge clk);
    chk("R4 hold input null", d_out, 8'h99);

    // Both low except pair0 input: partial fall.
    d_req = 1'b0; d_in = 8'h01;
    @(negedge clk);
    chk("R4 partial fall", d_out, 8'h01);
    chk("R6 hold partial null", d_ack, 1);
    d_in = '0;
    @(negedge clk);
    chk("R4 full fall", d_out, 0);
    chk("R6 ack lag", d_ack, 1);
    @(negedge clk);
    chk("R6 ack fall", d_ack, 0);

    // DATA offered while request low.
    d_in = enc(5);
    @(negedge clk);
    chk("R7 blocked", d_out, 0);
    d_req = 1'b1;
    @(negedge clk);
    chk("R3 word 5", d_out, 8'h66);
    d_req = 1'b0; d_in = '0;
    repeat (2) @(negedge clk);
    chk("R4 back to null", d_out, 0);
    chk("R6 back to request", d_ack, 0);

    // Streaming through the chain.
    for (int i = 0; i < NWORDS; i++) send(words[i]);
    while (rx_count < NWORDS) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R8 count", rx_count, NWORDS);
    chk("R2 no illegal code", illegal_seen, 0);
    chk("R9 chain idle", o2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule